// File: doc/BRIEF.md
# CAN controller mode and interrupt register core

This block is the register-level control core of a CAN peripheral. It sits on a simple 32-bit register bus and holds five registers: the mode register, a write-only command register, a read-only status register, an interrupt flag register and an interrupt enable register. The bit-level protocol engine, the error counters and the message buffers live elsewhere. They reach this core only as event pulses and status levels, and they receive its mode bits and command strobes.

The controller leaves reset in reset mode. The filter-select and sleep bits of the mode register can change only while that mode is active. Command writes become single-cycle strobes toward the protocol engine, and only outside reset mode. Event pulses set sticky interrupt flags. Software clears a flag by writing a one to its bit. A single level interrupt line is raised while any flag is set together with its enable bit.

The bus has no wait states. A write takes effect at the rising clock edge on which `bus_sel` and `bus_wr` are both high. Read data is a combinational decode of `bus_addr` over the registered state, so `bus_rdata` is valid in the same cycle that the address is presented.

Top module: `can_ctl_regs`

## Requirements
- R1: After reset, the mode register (offset 0x00) reads 0x1, status (0x08) reads 0x3C, the flag register (0x0C) and the enable register (0x10) read 0, `mode_out` is 0x01, and both `cmd_stb` and `irq` are low.
- R2: Mode bits 0 (reset mode), 1 (listen-only) and 2 (loopback) take the written value on every write to offset 0x00.
- R3: Mode bits 3 (single filter) and 4 (sleep) take the written value only if bit 0 was already 1 before the write. Otherwise they keep their previous value.
- R4: A write to offset 0x04 while bit 0 of the mode register is 0 drives write-data bits 5..0 onto `cmd_stb` for exactly the one cycle after the write edge. The bits are: 0 transmit, 1 abort, 2 release receive buffer, 3 clear overrun, 4 self-receive, 5 bus-off.
- R5: A write to offset 0x04 while in reset mode produces no strobe. Offset 0x04 always reads 0.
- R6: Offset 0x08 reads `stat_in` as registered at the previous rising edge. Its reset value is 0x3C, and writes to it have no effect.
- R7: A high bit of `evt_in` at a rising edge sets the matching flag, whatever the enable bit. The flags are: 0 receive valid, 1 transmit complete, 2 error warning, 3 data overrun, 4 wakeup, 5 error passive, 6 arbitration lost, 7 bus error.
- R8: A write to offset 0x0C clears each flag whose write-data bit is 1 and leaves the other flags unchanged.
- R9: When a clear and a new event hit the same flag in the same cycle, the flag stays set.
- R10: `irq` is high exactly when some flag bit and the same enable bit are both 1. The enable register at 0x10 is writable at any time.
- R11: Unused bits of every register read 0, and offsets 0x14, 0x1C and all unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write qualifier (1 = write) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| evt_in | input | 8 | Interrupt event pulses from the protocol engine |
| stat_in | input | 8 | Status levels from the protocol engine |
| mode_out | output | 5 | Current mode bits |
| cmd_stb | output | 6 | One-cycle command strobes |
| irq | output | 1 | Level interrupt request |

## Verification
Results fall due at different points relative to a stimulus. Mode bits, the enable register and flag changes driven by writes or events show up on `mode_out`, `bus_rdata` and `irq` just after the edge that samples them. A command strobe is high for exactly the cycle that follows its write edge and is low one cycle later. The status value is one register stage behind `stat_in`. The bench drives inputs 1 ns after a rising edge and advances a behavioural model on each rising edge. It compares every output at the falling edge, and its directed checks sample in the cycle right after the edge that carries each write.

// File: rtl/can_ctl_pkg.sv
package can_ctl_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int MODE_W  = 5;
  localparam int CMD_W   = 6;
  localparam int STAT_W  = 8;
  localparam int IRQ_W   = 8;

  localparam logic [ADDR_W-1:0] OFS_MODE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_ENA  = 8'h10;

  // mode bit positions; bit 0 gates configuration and commands
  localparam int MB_RESET  = 0;
  localparam int MB_LISTEN = 1;
  localparam int MB_LOOP   = 2;
  localparam int MB_FILT   = 3;
  localparam int MB_SLEEP  = 4;

  localparam logic [MODE_W-1:0] MODE_RST = 5'h01;
  localparam logic [STAT_W-1:0] STAT_RST = 8'h3C;
endpackage

// File: rtl/can_mode_reg.sv
module can_mode_reg
  import can_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q
);
  logic [MODE_W-1:0] mode_d;
  logic              in_reset;

  assign in_reset = mode_q[MB_RESET];

  always_comb begin
    mode_d = mode_q;
    if (wr_en) begin
      mode_d[MB_RESET]  = wdata[MB_RESET];
      mode_d[MB_LISTEN] = wdata[MB_LISTEN];
      mode_d[MB_LOOP]   = wdata[MB_LOOP];
      if (in_reset) begin
        mode_d[MB_FILT]  = wdata[MB_FILT];
        mode_d[MB_SLEEP] = wdata[MB_SLEEP];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RST;
    else if (wr_en) mode_q <= mode_d;
  end

  // R3: outside reset mode the filter and sleep bits never move
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_reset |=> $stable(mode_q[MB_SLEEP:MB_FILT]));
  // R2: a write lands its reset bit
  assert_reset_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mode_q[MB_RESET] == $past(wdata[MB_RESET]));
endmodule

// File: rtl/can_cmd_strobe.sv
module can_cmd_strobe
  import can_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             in_reset,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-1:0] stb
);
  logic [CMD_W-1:0] stb_d;

  always_comb begin
    stb_d = '0;
    if (wr_en && !in_reset) stb_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb <= '0;
    else        stb <= stb_d;
  end

  // R5: commands are dropped while in reset mode
  assert_no_cmd_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_reset) |=> stb == '0);
  // R4: a strobe only follows a write, so it lasts one cycle
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> stb == '0);
endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] evt,
  input  logic             clr_en,
  input  logic [IRQ_W-1:0] clr_bits,
  input  logic             ena_wr,
  input  logic [IRQ_W-1:0] ena_wdata,
  output logic [IRQ_W-1:0] flags,
  output logic [IRQ_W-1:0] enables,
  output logic             irq
);
  logic [IRQ_W-1:0] flags_d;
  logic [IRQ_W-1:0] clr_vec;

  assign clr_vec = clr_en ? clr_bits : '0;

  // per-flag next state: event has priority over the clear
  for (genvar i = 0; i < IRQ_W; i++) begin : g_flag
    always_comb begin
      flags_d[i] = flags[i];
      if (clr_vec[i]) flags_d[i] = 1'b0;
      if (evt[i])     flags_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      enables <= '0;
    else if (ena_wr) enables <= ena_wdata;
  end

  assign irq = |(flags & enables);

  // R7 R9: an event always leaves its flag set
  assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
  // R8: cleared bits without a competing event drop
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((flags & $past(clr_bits & ~evt)) == '0));
endmodule

// File: rtl/can_ctl_regs.sv
module can_ctl_regs
  import can_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IRQ_W-1:0]  evt_in,
  input  logic [STAT_W-1:0] stat_in,
  output logic [MODE_W-1:0] mode_out,
  output logic [CMD_W-1:0]  cmd_stb,
  output logic              irq
);
  logic              wr;
  logic              wr_mode, wr_cmd, wr_flag, wr_ena;
  logic [MODE_W-1:0] mode_q;
  logic [STAT_W-1:0] stat_q;
  logic [IRQ_W-1:0]  flags, enables;
  logic              unused_wdata;

  assign wr      = bus_sel && bus_wr;
  assign wr_mode = wr && (bus_addr == OFS_MODE);
  assign wr_cmd  = wr && (bus_addr == OFS_CMD);
  assign wr_flag = wr && (bus_addr == OFS_FLAG);
  assign wr_ena  = wr && (bus_addr == OFS_ENA);
  assign unused_wdata = ^bus_wdata[DATA_W-1:IRQ_W];

  can_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mode),
    .wdata(bus_wdata[MODE_W-1:0]), .mode_q(mode_q)
  );

  can_cmd_strobe u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cmd), .in_reset(mode_q[MB_RESET]),
    .wdata(bus_wdata[CMD_W-1:0]), .stb(cmd_stb)
  );

  can_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt_in),
    .clr_en(wr_flag), .clr_bits(bus_wdata[IRQ_W-1:0]),
    .ena_wr(wr_ena), .ena_wdata(bus_wdata[IRQ_W-1:0]),
    .flags(flags), .enables(enables), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RST;
    else        stat_q <= stat_in;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_MODE: bus_rdata = DATA_W'(mode_q);
      OFS_STAT: bus_rdata = DATA_W'(stat_q);
      OFS_FLAG: bus_rdata = DATA_W'(flags);
      OFS_ENA:  bus_rdata = DATA_W'(enables);
      default:  bus_rdata = '0;
    endcase
  end

  assign mode_out = mode_q;

  // R6: status follows its input one edge later
  assert_status_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat_q == $past(stat_in));
  // R10: no flags, no interrupt
  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);
endmodule

// File: tb/can_ctl_regs_test.sv
`timescale 1ns/1ps
module can_ctl_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_in = 0;
  logic [7:0]  stat_in = 8'h3C;
  logic [4:0]  mode_out;
  logic [5:0]  cmd_stb;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_mode = 1, m_stat = 'h3C, m_flag = 0, m_en = 0, m_stb = 0;

  always #2.5 clk = ~clk;

  can_ctl_regs uut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 1; m_stat = 'h3C; m_flag = 0; m_en = 0; m_stb = 0;
    end else begin
      bit w;
      int d;
      w = bus_sel && bus_wr;
      d = int'(bus_wdata);
      m_stb = (w && bus_addr == 8'h04 && (m_mode & 1) == 0) ? (d & 'h3F) : 0;
      m_flag = (m_flag & ~((w && bus_addr == 8'h0C) ? (d & 'hFF) : 0)) | int'(evt_in);
      if (w && bus_addr == 8'h10) m_en = d & 'hFF;
      if (w && bus_addr == 8'h00)
        m_mode = (d & 7) | (((m_mode & 1) != 0) ? (d & 'h18) : (m_mode & 'h18));
      m_stat = int'(stat_in);
    end
  end

  function automatic int exp_read(logic [7:0] a);
    case (a)
      8'h00: return m_mode;
      8'h08: return m_stat;
      8'h0C: return m_flag;
      8'h10: return m_en;
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 R3 mode_out", int'(mode_out), m_mode);
    chk("R4 R5 cmd_stb", int'(cmd_stb), m_stb);
    chk("R10 irq", int'(irq), ((m_flag & m_en) != 0) ? 1 : 0);
    chk("R6 R11 bus_rdata", int'(bus_rdata), exp_read(bus_addr));
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, string tag, int exp);
    bus_addr = a; #0.5;
    chk(tag, int'(bus_rdata), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    rd(8'h00, "R1 mode reset", 1);
    rd(8'h08, "R1 status reset", 'h3C);
    rd(8'h0C, "R1 flags reset", 0);
    rd(8'h10, "R1 enable reset", 0);
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 cmd reset", int'(cmd_stb), 0);
    rd(8'h14, "R11 unmapped 0x14", 0);
    rd(8'h1C, "R11 unmapped 0x1C", 0);
    // R5 command in reset mode ignored
    wr(8'h04, 32'h3F);
    chk("R5 no strobe in reset", int'(cmd_stb), 0);
    rd(8'h04, "R5 cmd reads 0", 0);
    // R3 filter and sleep set while in reset
    wr(8'h00, 32'h19);
    chk("R3 cfg in reset", int'(mode_out), 'h19);
    wr(8'h00, 32'h18);
    chk("R2 leave reset", int'(mode_out), 'h18);
    wr(8'h00, 32'h02);
    chk("R3 cfg held in normal", int'(mode_out), 'h1A);
    // R4 strobes
    wr(8'h04, 32'h01);
    chk("R4 tx strobe", int'(cmd_stb), 1);
    @(posedge clk); #1;
    chk("R4 strobe one cycle", int'(cmd_stb), 0);
    wr(8'h04, 32'hFFFF_FFFF);
    chk("R4 all strobes", int'(cmd_stb), 'h3F);
    // R2 + R11 wide write in normal mode
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, "R11 mode upper bits", 'h1F);
    wr(8'h00, 32'h0);
    chk("R3 clear in reset", int'(mode_out), 0);
    // R6 status
    stat_in = 8'hA5;
    wr(8'h08, 32'h0);
    rd(8'h08, "R6 status sampled", 'hA5);
    // R7 event with enable off
    @(posedge clk); #1; evt_in = 8'h81;
    @(posedge clk); #1; evt_in = 0;
    rd(8'h0C, "R7 flags latch", 'h81);
    chk("R10 masked irq", int'(irq), 0);
    wr(8'h10, 32'hFFFF_FF80);
    chk("R10 irq on enable", int'(irq), 1);
    rd(8'h10, "R11 enable width", 'h80);
    wr(8'h0C, 32'h80);
    rd(8'h0C, "R8 w1c keeps others", 1);
    chk("R10 irq after clear", int'(irq), 0);
    // R9 clear and event together
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'h01; evt_in = 8'h01;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; evt_in = 0;
    rd(8'h0C, "R9 event wins", 1);
    // random traffic checked cycle by cycle
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      bus_sel = 1'($urandom);
      bus_wr  = 1'($urandom);
      case ($urandom % 7)
        0: bus_addr = 8'h00; 1: bus_addr = 8'h04; 2: bus_addr = 8'h08;
        3: bus_addr = 8'h0C; 4: bus_addr = 8'h10; 5: bus_addr = 8'h14;
        default: bus_addr = 8'h1C;
      endcase
      bus_wdata = $urandom;
      evt_in  = (($urandom % 3) == 0) ? 8'($urandom) : 8'h0;
      stat_in = 8'($urandom);
    end
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; evt_in = 0;
    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule